// File: doc/BRIEF.md
# Protected Memory Range Access Filter

This block screens every memory access against one protected address window that belongs to a privileged management mode. The window is described by a pair of registers, a base register and a mask register, which software can program only while it runs in that mode. Each request carries an address, a read/write direction, write data, the requester's mode flag and the memory type that the general range-type resolver picked for the address. One cycle later the block returns its verdict: whether the access proceeds, the memory type to use, whether the write is suppressed, and a substituted read value.

When the window is enabled and a request from outside management mode falls inside it, the access is turned away without a fault. A write is dropped, and a read returns all-ones in every byte. The memory type is forced to uncached. Its verdict overrides whatever the general resolver chose, so an overlapping general range has no effect. Requests from management mode that fall in the window use the type held in the base register. Everything else passes through with the general type. A build-time parameter removes the feature: every register access then faults and every request passes.

Top module: `prot_range_filter`

## Requirements
- R1: After reset both registers read as zero, so the window is disabled, and no response is valid.
- R2: Base register: bits 7:0 hold the window memory type and bits 31:12 hold the base address. Mask register: bit 11 is the enable flag and bits 31:12 hold the mask. All other bits ignore writes and read as zero.
- R3: A register access (cfg_sel_i 0 = base, 1 = mask) returns its read data and its fault flag on the cycle after it is presented. Read data is zero for writes and for faulting accesses.
- R4: A register write with cfg_mgmt_i low raises cfg_fault_o and leaves both registers unchanged.
- R5: With FEATURE_EN = 0 every register access faults and reads zero, and every request passes with the general type.
- R6: An address hits the window when address bits above 31 are zero and (address AND mask) equals (base AND mask) over bits 31:12.
- R7: With the enable flag clear, every request passes with the general type, writes go through with their data, and the read substitute is zero.
- R8: A hit from management mode passes, and its type is the base register's type field.
- R9: A write hit from outside management mode does not pass. rsp_wsupp_o is high, rsp_wr_o is low, rsp_wdata_o is zero and the type is uncached (0x00).
- R10: A read hit from outside management mode does not pass. rsp_rdata_o is 0xFF in every byte and the type is uncached (0x00).
- R11: A miss passes with the general type in either mode, even when the general type differs from the window type.
- R12: Each request yields exactly one response on the next cycle, and back-to-back requests give back-to-back responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Register access strobe |
| cfg_we_i | input | 1 | Register access is a write |
| cfg_sel_i | input | 1 | 0 selects base, 1 selects mask |
| cfg_mgmt_i | input | 1 | Register accessor is in management mode |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data, one cycle later |
| cfg_fault_o | output | 1 | Register access faulted, one cycle later |
| req_valid_i | input | 1 | Memory request strobe |
| req_we_i | input | 1 | Request is a write |
| req_mgmt_i | input | 1 | Requester is in management mode |
| req_addr_i | input | ADDR_W | Physical address |
| req_wdata_i | input | DATA_W | Write data |
| gen_type_i | input | 8 | Type from the general range resolver |
| rsp_valid_o | output | 1 | Response valid |
| rsp_pass_o | output | 1 | Access may proceed |
| rsp_type_o | output | 8 | Memory type to use |
| rsp_wsupp_o | output | 1 | Write was suppressed |
| rsp_wr_o | output | 1 | Write is forwarded |
| rsp_wdata_o | output | DATA_W | Forwarded write data, zero unless forwarded |
| rsp_rdata_o | output | DATA_W | Substituted read value, zero unless substituted |

## Verification
The bench builds two instances with ADDR_W = 32 and DATA_W = 64. One has FEATURE_EN = 1. The other has FEATURE_EN = 0, receives the same stimulus and is checked every cycle, so the always-faulting, always-passing variant is covered next to the full one. With 64-bit data the all-ones read substitute is checked across eight bytes. A 2 MB window gives inclusive and exclusive boundaries at both edges, and the general type and window type differ, which makes an override or a missed override visible.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int unsigned TYPE_W    = 8;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned PAGE_LSB  = 12;
  localparam int unsigned VALID_BIT = 11;

  typedef logic [TYPE_W-1:0] mtype_t;
  localparam mtype_t MT_UC = 8'h00;

  typedef enum logic {SEL_BASE = 1'b0, SEL_MASK = 1'b1} reg_sel_e;

  localparam logic [REG_W-1:0] BASE_WMASK = 32'hFFFF_F0FF;
  localparam logic [REG_W-1:0] MASK_WMASK = 32'hFFFF_F800;
endpackage

// File: rtl/prf_regs.sv
module prf_regs
  import prf_pkg::*;
#(
  parameter bit FEATURE_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_valid_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic             cfg_mgmt_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic             cfg_fault_o,
  output logic [REG_W-1:0] base_o,
  output logic [REG_W-1:0] mask_o
);
  if (FEATURE_EN) begin : g_regs
    logic [REG_W-1:0] base_q, mask_q, rdata_q;
    logic             fault_q;
    logic             wr_ok, wr_bad;

    assign wr_ok  = cfg_valid_i && cfg_we_i && cfg_mgmt_i;
    assign wr_bad = cfg_valid_i && cfg_we_i && !cfg_mgmt_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q  <= '0;
        mask_q  <= '0;
        rdata_q <= '0;
        fault_q <= 1'b0;
      end else begin
        fault_q <= wr_bad;
        rdata_q <= '0;
        if (wr_ok && reg_sel_e'(cfg_sel_i) == SEL_BASE) base_q <= cfg_wdata_i & BASE_WMASK;
        if (wr_ok && reg_sel_e'(cfg_sel_i) == SEL_MASK) mask_q <= cfg_wdata_i & MASK_WMASK;
        if (cfg_valid_i && !cfg_we_i)
          rdata_q <= (reg_sel_e'(cfg_sel_i) == SEL_MASK) ? mask_q : base_q;
      end
    end

    assign base_o      = base_q;
    assign mask_o      = mask_q;
    assign cfg_rdata_o = rdata_q;
    assign cfg_fault_o = fault_q;

    // R4: an unprivileged write faults and changes nothing
    a_r4_unpriv_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_bad |=> cfg_fault_o && $stable(base_o) && $stable(mask_o));
    // R2: unused register bits stay clear
    a_r2_reserved_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((base_o & ~BASE_WMASK) == '0) && ((mask_o & ~MASK_WMASK) == '0));
  end else begin : g_absent
    logic fault_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fault_q <= 1'b0;
      else         fault_q <= cfg_valid_i;
    end
    assign base_o      = '0;
    assign mask_o      = '0;
    assign cfg_rdata_o = '0;
    assign cfg_fault_o = fault_q;

    // R5: without the feature every access faults
    a_r5_absent_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_valid_i |=> cfg_fault_o && cfg_rdata_o == '0);
  end
endmodule

// File: rtl/prf_match.sv
module prf_match
  import prf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  base_i,
  input  logic [REG_W-1:0]  mask_i,
  output logic              hit_o,
  output mtype_t            type_o
);
  localparam int unsigned NPG = REG_W - PAGE_LSB;

  logic [NPG-1:0] bit_ok;
  logic           high_zero;

  for (genvar i = 0; i < NPG; i++) begin : g_cmp
    assign bit_ok[i] = !mask_i[PAGE_LSB+i] ||
                       (addr_i[PAGE_LSB+i] == base_i[PAGE_LSB+i]);
  end

  if (ADDR_W > REG_W) begin : g_high
    assign high_zero = (addr_i[ADDR_W-1:REG_W] == '0);
  end else begin : g_nohigh
    assign high_zero = 1'b1;
  end

  assign hit_o  = mask_i[VALID_BIT] && high_zero && (&bit_ok);
  assign type_o = base_i[TYPE_W-1:0];
endmodule

// File: rtl/prf_decide.sv
module prf_decide
  import prf_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic              req_mgmt_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  mtype_t            gen_type_i,
  input  logic              hit_i,
  input  mtype_t            rng_type_i,
  output logic              rsp_valid_o,
  output logic              rsp_pass_o,
  output mtype_t            rsp_type_o,
  output logic              rsp_wsupp_o,
  output logic              rsp_wr_o,
  output logic [DATA_W-1:0] rsp_wdata_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  logic              block, wr_d;
  mtype_t            type_d;

  assign block  = hit_i && !req_mgmt_i;
  assign wr_d   = req_we_i && !block;
  assign type_d = block ? MT_UC : (hit_i ? rng_type_i : gen_type_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_pass_o  <= 1'b0;
      rsp_type_o  <= MT_UC;
      rsp_wsupp_o <= 1'b0;
      rsp_wr_o    <= 1'b0;
      rsp_wdata_o <= '0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_pass_o  <= req_valid_i && !block;
      rsp_type_o  <= req_valid_i ? type_d : MT_UC;
      rsp_wsupp_o <= req_valid_i && block && req_we_i;
      rsp_wr_o    <= req_valid_i && wr_d;
      rsp_wdata_o <= (req_valid_i && wr_d) ? req_wdata_i : '0;
      rsp_rdata_o <= (req_valid_i && block && !req_we_i) ? {DATA_W{1'b1}} : '0;
    end
  end

  a_r12_one_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r12_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r9_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && hit_i && !req_mgmt_i && req_we_i |=>
      !rsp_pass_o && rsp_wsupp_o && !rsp_wr_o && rsp_wdata_o == '0 && rsp_type_o == MT_UC);
  a_r10_read_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && hit_i && !req_mgmt_i && !req_we_i |=>
      !rsp_pass_o && rsp_rdata_o == {DATA_W{1'b1}} && rsp_type_o == MT_UC);
  a_r8_mgmt_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && hit_i && req_mgmt_i |=> rsp_pass_o && rsp_type_o == $past(rng_type_i));
  a_r11_miss_general: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !hit_i |=> rsp_pass_o && rsp_type_o == $past(gen_type_i) && !rsp_wsupp_o);
endmodule

// File: rtl/prot_range_filter.sv
module prot_range_filter
  import prf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter bit          FEATURE_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic              cfg_mgmt_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_fault_o,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic              req_mgmt_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [7:0]        gen_type_i,
  output logic              rsp_valid_o,
  output logic              rsp_pass_o,
  output logic [7:0]        rsp_type_o,
  output logic              rsp_wsupp_o,
  output logic              rsp_wr_o,
  output logic [DATA_W-1:0] rsp_wdata_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  logic [REG_W-1:0] base, mask;
  logic             hit;
  mtype_t           rng_type;

  prf_regs #(.FEATURE_EN(FEATURE_EN)) u_regs (
    .clk_i, .rst_ni, .cfg_valid_i, .cfg_we_i, .cfg_sel_i, .cfg_mgmt_i,
    .cfg_wdata_i, .cfg_rdata_o, .cfg_fault_o, .base_o(base), .mask_o(mask)
  );

  prf_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_i(req_addr_i), .base_i(base), .mask_i(mask), .hit_o(hit), .type_o(rng_type)
  );

  prf_decide #(.DATA_W(DATA_W)) u_decide (
    .clk_i, .rst_ni, .req_valid_i, .req_we_i, .req_mgmt_i, .req_wdata_i,
    .gen_type_i, .hit_i(hit), .rng_type_i(rng_type),
    .rsp_valid_o, .rsp_pass_o, .rsp_type_o, .rsp_wsupp_o, .rsp_wr_o,
    .rsp_wdata_o, .rsp_rdata_o
  );
endmodule

// File: tb/prot_range_filter_tb.sv
module prot_range_filter_tb;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid = 0, cfg_we = 0, cfg_sel = 0, cfg_mgmt = 0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 0, req_we = 0, req_mgmt = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [7:0]    gen_type = '0;

  logic [31:0]   cfg_rdata, nf_cfg_rdata;
  logic          cfg_fault, nf_cfg_fault;
  logic          rsp_valid, rsp_pass, rsp_wsupp, rsp_wr;
  logic [7:0]    rsp_type;
  logic [DW-1:0] rsp_wdata, rsp_rdata;
  logic          nf_valid, nf_pass, nf_wsupp, nf_wr;
  logic [7:0]    nf_type;
  logic [DW-1:0] nf_wdata, nf_rdata;

  always #2 clk = ~clk;

  prot_range_filter #(.ADDR_W(AW), .DATA_W(DW), .FEATURE_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid), .cfg_we_i(cfg_we),
    .cfg_sel_i(cfg_sel), .cfg_mgmt_i(cfg_mgmt), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .cfg_fault_o(cfg_fault),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_mgmt_i(req_mgmt),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .gen_type_i(gen_type),
    .rsp_valid_o(rsp_valid), .rsp_pass_o(rsp_pass), .rsp_type_o(rsp_type),
    .rsp_wsupp_o(rsp_wsupp), .rsp_wr_o(rsp_wr), .rsp_wdata_o(rsp_wdata),
    .rsp_rdata_o(rsp_rdata)
  );

  prot_range_filter #(.ADDR_W(AW), .DATA_W(DW), .FEATURE_EN(1'b0)) u_dut_nf (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid), .cfg_we_i(cfg_we),
    .cfg_sel_i(cfg_sel), .cfg_mgmt_i(cfg_mgmt), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(nf_cfg_rdata), .cfg_fault_o(nf_cfg_fault),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_mgmt_i(req_mgmt),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .gen_type_i(gen_type),
    .rsp_valid_o(nf_valid), .rsp_pass_o(nf_pass), .rsp_type_o(nf_type),
    .rsp_wsupp_o(nf_wsupp), .rsp_wr_o(nf_wr), .rsp_wdata_o(nf_wdata),
    .rsp_rdata_o(nf_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    int            due;
    string         tag;
    logic          pass, wsupp, wr;
    logic [7:0]    mtype, gen;
    logic [DW-1:0] wdata, rdata, nf_wdata;
    logic          nf_wr;
  } item_t;
  item_t sb[$];

  // bench-side copy of the programmed window
  logic [31:0] m_base = '0, m_mask = '0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      finish_test();
    end
  end

  // monitor: pop and compare at the due cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (sb.size() != 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " valid R12"}, DW'(rsp_valid), DW'(1'b1));
        check({it.tag, " pass"},  DW'(rsp_pass),  DW'(it.pass));
        check({it.tag, " type"},  DW'(rsp_type),  DW'(it.mtype));
        check({it.tag, " wsupp"}, DW'(rsp_wsupp), DW'(it.wsupp));
        check({it.tag, " wr"},    DW'(rsp_wr),    DW'(it.wr));
        check({it.tag, " wdata"}, rsp_wdata,      it.wdata);
        check({it.tag, " rdata"}, rsp_rdata,      it.rdata);
        // R5: feature-less instance always passes with the general type
        check({it.tag, " R5 nf pass"},  DW'({nf_valid, nf_pass, nf_wsupp}), DW'(3'b110));
        check({it.tag, " R5 nf type"},  DW'(nf_type), DW'(it.gen));
        check({it.tag, " R5 nf wr"},    DW'(nf_wr), DW'(it.nf_wr));
        check({it.tag, " R5 nf wdata"}, nf_wdata, it.nf_wdata);
        check({it.tag, " R5 nf rdata"}, nf_rdata, '0);
      end else begin
        check("R12 no spurious response", DW'(rsp_valid), DW'(1'b0));
      end
    end
  end

  // driver: one request per call; consecutive calls are back to back
  task automatic request(input string tag, input logic [AW-1:0] a, input logic we,
                         input logic mgmt, input logic [DW-1:0] wd, input logic [7:0] gt);
    item_t it;
    logic  hit, blk;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_mgmt = mgmt;
    req_wdata = wd; gen_type = gt;
    hit = m_mask[11] && ((a[31:12] & m_mask[31:12]) == (m_base[31:12] & m_mask[31:12]));
    blk = hit && !mgmt;
    it.due      = cyc + 1;
    it.tag      = tag;
    it.pass     = !blk;
    it.mtype    = blk ? 8'h00 : (hit ? m_base[7:0] : gt);
    it.wsupp    = blk && we;
    it.wr       = we && !blk;
    it.wdata    = (we && !blk) ? wd : '0;
    it.rdata    = (blk && !we) ? {DW{1'b1}} : '0;
    it.gen      = gt;
    it.nf_wr    = we;
    it.nf_wdata = we ? wd : '0;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // register access: checks fault and read data on the next cycle
  task automatic cfg(input string tag, input logic we, input logic sel, input logic mgmt,
                     input logic [31:0] wd, input logic exp_fault, input logic [31:0] exp_rd);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_we = we; cfg_sel = sel; cfg_mgmt = mgmt; cfg_wdata = wd;
    @(negedge clk);
    cfg_valid = 1'b0;
    check({tag, " fault"}, DW'(cfg_fault), DW'(exp_fault));
    check({tag, " rdata"}, DW'(cfg_rdata), DW'(exp_rd));
    check({tag, " R5 nf fault"}, DW'(nf_cfg_fault), DW'(1'b1));
    check({tag, " R5 nf rdata"}, DW'(nf_cfg_rdata), '0);
  endtask

  localparam logic [DW-1:0] WD = 64'h0123_4567_89AB_CDEF;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid idle", DW'(rsp_valid), DW'(1'b0));
    cfg("R1 base reset", 1'b0, 1'b0, 1'b1, '0, 1'b0, 32'h0);
    cfg("R1 mask reset", 1'b0, 1'b1, 1'b0, '0, 1'b0, 32'h0);

    // R7: window disabled, everything passes
    request("R7 rd nonmgmt", 32'h0020_1000, 1'b0, 1'b0, '0, 8'h06);
    request("R7 wr nonmgmt", 32'h0030_0000, 1'b1, 1'b0, WD, 8'h04);
    idle(1);

    // R4: unprivileged writes fault and are dropped; R3 write returns zero data
    cfg("R4 base unpriv wr", 1'b1, 1'b0, 1'b0, 32'h0020_0005, 1'b1, 32'h0);
    cfg("R4 base unchanged", 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h0);

    // R2: program base 2 MB type 0x05, 2 MB mask, enabled; reserved bits dropped
    cfg("R2 base wr", 1'b1, 1'b0, 1'b1, 32'h0020_0F05, 1'b0, 32'h0);
    m_base = 32'h0020_0005;
    cfg("R2 mask wr", 1'b1, 1'b1, 1'b1, 32'hFFE0_0BFF, 1'b0, 32'h0);
    m_mask = 32'hFFE0_0800;
    cfg("R2 base rd", 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h0020_0005);
    cfg("R3 mask rd", 1'b0, 1'b1, 1'b1, '0, 1'b0, 32'hFFE0_0800);

    // R8/R9/R10/R6/R11 back to back (R12)
    request("R8 mgmt rd hit",      32'h0020_1000, 1'b0, 1'b1, '0, 8'h06);
    request("R8 mgmt wr hit",      32'h003F_F000, 1'b1, 1'b1, WD, 8'h06);
    request("R10 unpriv rd hit",   32'h0020_0000, 1'b0, 1'b0, '0, 8'h06);
    request("R9 unpriv wr hit",    32'h003F_FFFC, 1'b1, 1'b0, WD, 8'h06);
    request("R6 below window",     32'h001F_FFFC, 1'b0, 1'b0, '0, 8'h06);
    request("R6 above window",     32'h0040_0000, 1'b1, 1'b0, WD, 8'h01);
    request("R11 far miss mgmt",   32'hFF20_0000, 1'b0, 1'b1, '0, 8'h04);
    request("R10 unpriv rd hit 2", 32'h002A_B123, 1'b0, 1'b0, '0, 8'h00);
    idle(1);

    // R4: unprivileged attempt to disable window is ignored
    cfg("R4 mask unpriv wr", 1'b1, 1'b1, 1'b0, 32'h0, 1'b1, 32'h0);
    cfg("R4 mask unchanged", 1'b0, 1'b1, 1'b0, '0, 1'b0, 32'hFFE0_0800);
    request("R9 still blocked", 32'h0030_0000, 1'b1, 1'b0, WD, 8'h06);
    idle(1);

    // R7: privileged disable restores pass-through
    cfg("R7 mask clear", 1'b1, 1'b1, 1'b1, 32'hFFE0_0000, 1'b0, 32'h0);
    m_mask = 32'hFFE0_0000;
    request("R7 rd after disable", 32'h0020_0000, 1'b0, 1'b0, '0, 8'h06);
    request("R7 wr after disable", 32'h0030_0000, 1'b1, 1'b0, WD, 8'h04);
    idle(3);

    check("R12 scoreboard drained", DW'(sb.size()), '0);
    finish_test();
  end
endmodule